// File: doc/BRIEF.md
# x86 Instruction Prefix Scanner

This block looks at the first bytes of one x86 instruction and finds where its prefix bytes stop. The caller presents a window of up to fifteen instruction bytes together with a flag for 64-bit or 32-bit code, and pulses a valid strobe. One cycle later a done strobe comes back with the results:

- how many leading bytes are prefixes, and the position of the opcode byte;
- the effective operand size and address size;
- the fields of a REX byte that is in force;
- the segment override, if any;
- whether a LOCK byte was seen;
- whether the prefix run leaves no room for an opcode inside the fifteen-byte limit.

The block does not decode the opcode, ModRM, SIB or immediates, and it never fetches memory. A front end of a decoder uses it to strip prefixes before the opcode tables are consulted.

Window byte i lies at bits [8*i+7 : 8*i] of the window input, and byte 0 is the first byte of the instruction. Results stay on the outputs until the next valid strobe.

Top module: `x86_pfx_scan`

## Requirements
- R1: A window accepted with `in_valid` high at a clock edge produces `out_done` high for exactly the following cycle. `out_done` is low in every cycle that does not follow an accepted window.
- R2: The bytes F0h, F2h, F3h, 26h, 2Eh, 36h, 3Eh, 64h, 65h, 66h and 67h are prefixes in both modes. `pfx_count` equals the number of consecutive prefix bytes from byte 0, and `opc_pos` equals that same count. Any other byte ends the scan.
- R3: Bytes 40h–4Fh count as prefixes only when `mode64` is 1. With `mode64` 0 they end the scan, and `rex_hit` is 0.
- R4: `rex_hit` is 1 only when the last prefix byte, directly before the opcode, is a REX byte. In that case `rex_w`, `rex_r`, `rex_x` and `rex_b` are its bits 3, 2, 1 and 0. Otherwise all four are 0. Any number of REX bytes may appear, and a REX byte followed by another prefix is discarded.
- R5: `op_size` uses the encoding 0 = 16-bit, 1 = 32-bit, 2 = 64-bit. It is 2 when `rex_hit` and `rex_w` are both 1. Otherwise it is 0 if a 66h prefix is present, and 1 if not.
- R6: `addr_size` uses the same encoding as `op_size`. In 64-bit mode it is 2, or 1 when a 67h prefix is present. In 32-bit mode it is 1, or 0 when a 67h prefix is present.
- R7: `seg_ovr` uses the encoding 0 = none, 1 = ES (26h), 2 = CS (2Eh), 3 = SS (36h), 4 = DS (3Eh), 5 = FS (64h), 6 = GS (65h). When several overrides appear, the last one scanned sets the value.
- R8: `lock_seen` is 1 exactly when an F0h byte lies within the prefix run.
- R9: `len_fault` is 1 exactly when all fifteen window bytes are prefixes. In that case `pfx_count` is 15.
- R10: While `in_valid` is low, all result outputs keep their values, whatever the window and mode inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the window this cycle |
| mode64 | input | 1 | 1 = 64-bit code, 0 = 32-bit code |
| win_bytes | input | 120 | Instruction bytes; byte 0 in bits 7:0 |
| out_done | output | 1 | Results valid, one cycle after acceptance |
| pfx_count | output | 4 | Number of leading prefix bytes |
| opc_pos | output | 4 | Index of the opcode byte |
| op_size | output | 2 | Effective operand size (0/1/2 = 16/32/64) |
| addr_size | output | 2 | Effective address size (0/1/2 = 16/32/64) |
| rex_hit | output | 1 | A REX byte directly precedes the opcode |
| rex_w | output | 1 | REX bit 3 |
| rex_r | output | 1 | REX bit 2 |
| rex_x | output | 1 | REX bit 1 |
| rex_b | output | 1 | REX bit 0 |
| seg_ovr | output | 3 | Segment override code |
| lock_seen | output | 1 | LOCK prefix present |
| len_fault | output | 1 | Prefixes fill the fifteen-byte limit |

## Verification
The assertions check on every cycle the properties that do not depend on the window contents:

- the done strobe tracks acceptance;
- results hold while nothing is accepted;
- 32-bit mode never reports REX or 64-bit addressing;
- a 64-bit operand size implies an effective REX.W;
- a length fault comes only with a full count.

Which byte values are prefixes, the last-wins rule for segment overrides, the rule that only the final REX byte counts, and the exact sizes can only be shown by the bench's sweeps:

- every first-byte value in both modes;
- every ordered triple from a mixed set of prefix and non-prefix bytes;
- prefix chains of every length up to the limit.

// File: rtl/x86_pfx_pkg.sv
package x86_pfx_pkg;

  typedef enum logic [2:0] {
    SEG_NONE = 3'd0,
    SEG_ES   = 3'd1,
    SEG_CS   = 3'd2,
    SEG_SS   = 3'd3,
    SEG_DS   = 3'd4,
    SEG_FS   = 3'd5,
    SEG_GS   = 3'd6
  } seg_e;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ32 = 2'd1,
    SZ64 = 2'd2
  } size_e;

  typedef struct packed {
    logic is_pfx;
    logic is_rex;
    logic is_lock;
    logic is_opsz;
    logic is_adsz;
    seg_e seg;
  } byte_cls_t;

endpackage

// File: rtl/x86_pfx_byte_cls.sv
module x86_pfx_byte_cls
  import x86_pfx_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic       mode64_i,
  output byte_cls_t  cls_o
);

  always_comb begin
    cls_o = '{is_pfx: 1'b0, is_rex: 1'b0, is_lock: 1'b0, is_opsz: 1'b0,
              is_adsz: 1'b0, seg: SEG_NONE};
    unique case (byte_i)
      8'hF0: begin cls_o.is_pfx = 1'b1; cls_o.is_lock = 1'b1; end
      8'hF2, 8'hF3: cls_o.is_pfx = 1'b1;
      8'h26: begin cls_o.is_pfx = 1'b1; cls_o.seg = SEG_ES; end
      8'h2E: begin cls_o.is_pfx = 1'b1; cls_o.seg = SEG_CS; end
      8'h36: begin cls_o.is_pfx = 1'b1; cls_o.seg = SEG_SS; end
      8'h3E: begin cls_o.is_pfx = 1'b1; cls_o.seg = SEG_DS; end
      8'h64: begin cls_o.is_pfx = 1'b1; cls_o.seg = SEG_FS; end
      8'h65: begin cls_o.is_pfx = 1'b1; cls_o.seg = SEG_GS; end
      8'h66: begin cls_o.is_pfx = 1'b1; cls_o.is_opsz = 1'b1; end
      8'h67: begin cls_o.is_pfx = 1'b1; cls_o.is_adsz = 1'b1; end
      default: begin
        // 40h..4Fh: REX in 64-bit code, one-byte INC/DEC opcodes otherwise
        if (mode64_i && (byte_i[7:4] == 4'h4)) begin
          cls_o.is_pfx = 1'b1;
          cls_o.is_rex = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/x86_pfx_span.sv
module x86_pfx_span #(
  parameter int N  = 15,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pfx_vec_i,
  output logic [CW-1:0] count_o,
  output logic          full_o
);

  logic found;

  always_comb begin
    count_o = CW'(N);
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && !pfx_vec_i[i]) begin
        count_o = CW'(i);
        found   = 1'b1;
      end
    end
    full_o = &pfx_vec_i;
  end

endmodule

// File: rtl/x86_pfx_attr.sv
module x86_pfx_attr
  import x86_pfx_pkg::*;
#(
  parameter int N  = 15,
  parameter int CW = $clog2(N + 1)
) (
  input  byte_cls_t [N-1:0] cls_i,
  input  logic [8*N-1:0]    win_i,
  input  logic [CW-1:0]     count_i,
  input  logic              mode64_i,
  output size_e             op_size_o,
  output size_e             addr_size_o,
  output seg_e              seg_o,
  output logic              lock_o,
  output logic              rex_hit_o,
  output logic [3:0]        rex_bits_o
);

  logic any_opsz;
  logic any_adsz;

  always_comb begin
    any_opsz   = 1'b0;
    any_adsz   = 1'b0;
    lock_o     = 1'b0;
    seg_o      = SEG_NONE;
    rex_hit_o  = 1'b0;
    rex_bits_o = 4'h0;
    for (int i = 0; i < N; i++) begin
      if (CW'(i) < count_i) begin
        any_opsz = any_opsz | cls_i[i].is_opsz;
        any_adsz = any_adsz | cls_i[i].is_adsz;
        lock_o   = lock_o | cls_i[i].is_lock;
        if (cls_i[i].seg != SEG_NONE) seg_o = cls_i[i].seg;  // later wins
      end
      // only the prefix in the slot just before the opcode may supply REX
      if ((CW'(i) + CW'(1)) == count_i && cls_i[i].is_rex) begin
        rex_hit_o  = 1'b1;
        rex_bits_o = win_i[8*i +: 4];
      end
    end

    if (rex_hit_o && rex_bits_o[3]) op_size_o = SZ64;
    else if (any_opsz)              op_size_o = SZ16;
    else                            op_size_o = SZ32;

    if (mode64_i) addr_size_o = any_adsz ? SZ32 : SZ64;
    else          addr_size_o = any_adsz ? SZ16 : SZ32;
  end

endmodule

// File: rtl/x86_pfx_scan.sv
module x86_pfx_scan
  import x86_pfx_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int CW      = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 mode64,
  input  logic [8*MAX_LEN-1:0] win_bytes,
  output logic                 out_done,
  output logic [CW-1:0]        pfx_count,
  output logic [CW-1:0]        opc_pos,
  output logic [1:0]           op_size,
  output logic [1:0]           addr_size,
  output logic                 rex_hit,
  output logic                 rex_w,
  output logic                 rex_r,
  output logic                 rex_x,
  output logic                 rex_b,
  output logic [2:0]           seg_ovr,
  output logic                 lock_seen,
  output logic                 len_fault
);

  typedef struct packed {
    logic [CW-1:0] count;
    size_e         opsz;
    size_e         adsz;
    seg_e          seg;
    logic          lock;
    logic          rex_hit;
    logic [3:0]    rex;
    logic          fault;
  } res_t;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // per-byte classification
  byte_cls_t [MAX_LEN-1:0] cls_vec;
  logic      [MAX_LEN-1:0] pfx_vec;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_cls
    x86_pfx_byte_cls u_cls (
      .byte_i   (win_bytes[8*g +: 8]),
      .mode64_i (mode64),
      .cls_o    (cls_vec[g])
    );
    assign pfx_vec[g] = cls_vec[g].is_pfx;
  end

  logic [CW-1:0] span_cnt;
  logic          span_full;

  x86_pfx_span #(.N(MAX_LEN), .CW(CW)) u_span (
    .pfx_vec_i (pfx_vec),
    .count_o   (span_cnt),
    .full_o    (span_full)
  );

  size_e      a_opsz, a_adsz;
  seg_e       a_seg;
  logic       a_lock, a_rex_hit;
  logic [3:0] a_rex;

  x86_pfx_attr #(.N(MAX_LEN), .CW(CW)) u_attr (
    .cls_i       (cls_vec),
    .win_i       (win_bytes),
    .count_i     (span_cnt),
    .mode64_i    (mode64),
    .op_size_o   (a_opsz),
    .addr_size_o (a_adsz),
    .seg_o       (a_seg),
    .lock_o      (a_lock),
    .rex_hit_o   (a_rex_hit),
    .rex_bits_o  (a_rex)
  );

  // next state
  res_t res_d, res_q;
  logic done_d, done_q;

  always_comb begin
    res_d  = res_q;
    done_d = in_valid;
    if (in_valid) begin
      res_d.count   = span_cnt;
      res_d.opsz    = a_opsz;
      res_d.adsz    = a_adsz;
      res_d.seg     = a_seg;
      res_d.lock    = a_lock;
      res_d.rex_hit = a_rex_hit;
      res_d.rex     = a_rex;
      res_d.fault   = span_full;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      done_q <= 1'b0;
      res_q  <= '{count: '0, opsz: SZ32, adsz: SZ32, seg: SEG_NONE,
                  lock: 1'b0, rex_hit: 1'b0, rex: 4'h0, fault: 1'b0};
    end else begin
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign out_done  = done_q;
  assign pfx_count = res_q.count;
  assign opc_pos   = res_q.count;
  assign op_size   = res_q.opsz;
  assign addr_size = res_q.adsz;
  assign seg_ovr   = res_q.seg;
  assign lock_seen = res_q.lock;
  assign rex_hit   = res_q.rex_hit;
  assign rex_w     = res_q.rex[3];
  assign rex_r     = res_q.rex[2];
  assign rex_x     = res_q.rex[1];
  assign rex_b     = res_q.rex[0];
  assign len_fault = res_q.fault;

  // R1: done strobe follows acceptance by one cycle
  p_done_follow_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_done);
  p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_done);
  // R10: results hold while nothing is accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(pfx_count) && $stable(seg_ovr) && $stable(op_size)
                  && $stable(addr_size) && $stable(lock_seen) && $stable(rex_hit)
                  && $stable(len_fault));
  // R3: no REX effect in 32-bit code
  p_no_rex32_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !mode64) |=> !rex_hit);
  // R6: 32-bit code never reports 64-bit addressing, 64-bit code never 16-bit
  p_adsz32_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !mode64) |=> addr_size != 2'd2);
  p_adsz64_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && mode64) |=> addr_size != 2'd0);
  // R5: 64-bit operands only through an effective REX.W
  p_opsz64_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_size == 2'd2) |-> (rex_hit && rex_w));
  // R4: REX fields are zero when no REX is in force
  p_rex_zero_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    !rex_hit |-> !(rex_w || rex_r || rex_x || rex_b));
  // R9: a length fault means the whole window was prefixes
  p_fault_full_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    len_fault |-> (pfx_count == CW'(MAX_LEN)));

endmodule

// File: tb/x86_pfx_scan_test.sv
`timescale 1ns/1ps
module x86_pfx_scan_test;

  localparam int NB = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          mode64 = 1'b0;
  logic [8*NB-1:0] win_bytes = '0;
  logic          out_done;
  logic [3:0]    pfx_count, opc_pos;
  logic [1:0]    op_size, addr_size;
  logic          rex_hit, rex_w, rex_r, rex_x, rex_b;
  logic [2:0]    seg_ovr;
  logic          lock_seen, len_fault;

  always #2 clk = ~clk;  // 250 MHz

  x86_pfx_scan uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64),
    .win_bytes(win_bytes), .out_done(out_done), .pfx_count(pfx_count),
    .opc_pos(opc_pos), .op_size(op_size), .addr_size(addr_size),
    .rex_hit(rex_hit), .rex_w(rex_w), .rex_r(rex_r), .rex_x(rex_x),
    .rex_b(rex_b), .seg_ovr(seg_ovr), .lock_seen(lock_seen),
    .len_fault(len_fault)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected results, computed from the requirements
  int e_cnt, e_op, e_ad, e_seg, e_lock, e_hit, e_rex, e_fault;

  task automatic model(input logic [8*NB-1:0] w, input logic m64);
    bit stop = 0, o66 = 0, a67 = 0, last_rex = 0;
    logic [7:0] b;
    e_cnt = 0; e_seg = 0; e_lock = 0; e_rex = 0;
    for (int i = 0; i < NB; i++) begin
      if (!stop) begin
        b = w[8*i +: 8];
        if (b == 8'hF0 || b == 8'hF2 || b == 8'hF3 || b == 8'h66 || b == 8'h67 ||
            b == 8'h26 || b == 8'h2E || b == 8'h36 || b == 8'h3E ||
            b == 8'h64 || b == 8'h65 || (m64 && b[7:4] == 4'h4)) begin
          e_cnt++;
          if (b == 8'hF0) e_lock = 1;
          if (b == 8'h66) o66 = 1;
          if (b == 8'h67) a67 = 1;
          if (b == 8'h26) e_seg = 1;
          if (b == 8'h2E) e_seg = 2;
          if (b == 8'h36) e_seg = 3;
          if (b == 8'h3E) e_seg = 4;
          if (b == 8'h64) e_seg = 5;
          if (b == 8'h65) e_seg = 6;
          last_rex = (b[7:4] == 4'h4);
          e_rex = last_rex ? int'(b[3:0]) : 0;
        end else stop = 1;
      end
    end
    e_hit = last_rex ? 1 : 0;
    e_op  = (last_rex && e_rex[3]) ? 2 : (o66 ? 0 : 1);
    e_ad  = m64 ? (a67 ? 1 : 2) : (a67 ? 0 : 1);
    e_fault = (e_cnt == NB) ? 1 : 0;
  endtask

  task automatic cmp_all();
    chk("R2", "pfx_count", int'(pfx_count), e_cnt);
    chk("R2", "opc_pos", int'(opc_pos), e_cnt);
    chk("R5", "op_size", int'(op_size), e_op);
    chk("R6", "addr_size", int'(addr_size), e_ad);
    chk("R7", "seg_ovr", int'(seg_ovr), e_seg);
    chk("R8", "lock_seen", int'(lock_seen), e_lock);
    chk("R4", "rex_hit", int'(rex_hit), e_hit);
    chk("R4", "rex_wrxb", int'({rex_w, rex_r, rex_x, rex_b}), e_rex);
    chk("R9", "len_fault", int'(len_fault), e_fault);
  endtask

  // one scan: drive at a falling edge, result registered at the next rising edge
  task automatic scan(input logic [8*NB-1:0] w, input logic m64, input bit hold_chk);
    @(negedge clk);
    win_bytes = w; mode64 = m64; in_valid = 1'b1;
    model(w, m64);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "out_done", int'(out_done), 1);
    cmp_all();
    if (hold_chk) begin
      win_bytes = {$urandom, $urandom, $urandom, $urandom};
      mode64 = ~m64;
      @(negedge clk);
      chk("R1", "out_done_low", int'(out_done), 0);
      cmp_all();  // R10: nothing moved while in_valid was low
    end
  endtask

  function automatic logic [8*NB-1:0] fill(input logic [7:0] v);
    logic [8*NB-1:0] r;
    for (int i = 0; i < NB; i++) r[8*i +: 8] = v;
    return r;
  endfunction

  logic [7:0] mix [20] = '{8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E,
                           8'h64, 8'h65, 8'h66, 8'h67, 8'h40, 8'h41, 8'h44,
                           8'h48, 8'h4F, 8'h4A, 8'h90, 8'h04, 8'h0F};
  logic [7:0] chain [8] = '{8'h66, 8'h48, 8'h2E, 8'hF0, 8'h67, 8'h45, 8'h65, 8'hF3};

  initial begin
    logic [8*NB-1:0] w;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1", "reset out_done", int'(out_done), 0);
    chk("R2", "reset pfx_count", int'(pfx_count), 0);
    chk("R7", "reset seg_ovr", int'(seg_ovr), 0);
    chk("R8", "reset lock_seen", int'(lock_seen), 0);
    chk("R9", "reset len_fault", int'(len_fault), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3: every value of the first byte, both modes
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 256; b++) begin
        w = fill(8'hCC);
        w[7:0] = 8'(b);
        w[15:8] = 8'h04;
        scan(w, 1'(m), 1'b0);
      end

    // R4 R5 R7 R8: ordered triples, opcode 04h after, holds checked (R10)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 20; a++)
        for (int b = 0; b < 20; b++)
          for (int c = 0; c < 20; c++) begin
            w = fill(8'hCC);
            w[7:0] = mix[a]; w[15:8] = mix[b]; w[23:16] = mix[c];
            w[31:24] = 8'h04;
            scan(w, 1'(m), (c % 4) == 0);
          end

    // R9: chains of each length up to the full window
    for (int m = 0; m < 2; m++)
      for (int len = 0; len <= NB; len++) begin
        w = fill(8'h90);
        for (int i = 0; i < len; i++) w[8*i +: 8] = chain[(i + m) % 8];
        scan(w, 1'(m), 1'b1);
        w = fill(8'h90);
        for (int i = 0; i < len; i++) w[8*i +: 8] = 8'h40 + 8'(i);  // R3 REX run
        scan(w, 1'(m), 1'b0);
      end

    // R9: fault with redundant 66h only
    scan(fill(8'h66), 1'b0, 1'b1);
    scan(fill(8'h66), 1'b1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule